// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits on the host side of an asynchronous parallel NOR flash bus. It turns one request into the full bus conversation the flash needs. A request is an operation (word program, sector erase or whole-chip erase), an address and a data word. The block writes the unlock and command words, then reads status until the embedded operation in the flash has finished or has given up. Each bus cycle is built from clock counts set by parameters: a setup phase, a chip-enable low phase, a hold phase and a chip-enable high gap.

Completion is found by reading the target location. While the flash is busy, bit 7 of the read word is the complement of the final value. When bit 7 matches, the whole word is compared with the expected value: the programmed word for a program, all ones for an erase. Bit 5 set on a mismatching read means the flash ran out of time. The block then reads once more before it decides. If any operation fails, the block writes the read-mode reset command before it reports.

The requester uses a valid/ready handshake, and only one request can be open at a time. A one-cycle done pulse carries a pass or fail flag.

Top module: `pflash_seq`

## Requirements
- R1: Out of reset, chip enable, write enable and output enable are all high, the data bus is not driven, `req_ready` is 1 and `done` is 0.
- R2: A program request (op code 0) writes, in order, 0xAA to address 0x555, 0x55 to address 0x2AA, 0xA0 to address 0x555, and then the request data to the request address.
- R3: A sector erase request (op code 1) writes, in order, 0x555/0xAA, 0x2AA/0x55, 0x555/0x80, 0x555/0xAA, 0x2AA/0x55, and then 0x30 to the request address.
- R4: A chip erase request (op code 2) writes the same first five cycles as R3, and then 0x10 to address 0x555.
- R5: Every write cycle works as follows. Write enable goes low together with a valid address and driven data. Both stay unchanged for max(T_AS,T_DS) cycles with chip enable high. Chip enable is then low for exactly T_CP cycles. Address, data and low write enable are held for max(T_AH,T_DH) cycles after chip enable rises. After that, chip enable stays high for T_CPH cycles with write enable high.
- R6: Write enable and output enable are never low in the same cycle, and the data bus is driven only while write enable is low.
- R7: After the last command write, the block reads the request address. It keeps reading while bit 7 differs from bit 7 of the expected word and bit 5 is 0. The expected word is the request data for a program and all ones for an erase. When bit 7 matches and the whole word equals the expected word, it reports pass.
- R8: If a status read has bit 7 mismatching and bit 5 set, exactly one further read follows. If that read equals the expected word, the block reports pass.
- R9: The block fails in two cases: the extra read of R8 does not equal the expected word, or bit 7 matches but the whole word differs. In either case it writes 0xF0 to address 0 and then reports done with `done_ok` = 0.
- R10: `req_ready` is high only while idle, and a request is taken on a cycle with `req_valid` and `req_ready` both high. `req_ready` stays low until `done`. `done` is a single-cycle pulse, and `req_ready` is 1 again in the cycle after it.
- R11: Op code 3 is rejected. `done` pulses with `done_ok` = 0 in the cycle after acceptance, and no bus cycle is run.
- R12: Every status read holds chip enable and output enable low together for exactly T_RD cycles, with write enable high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_op | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 rejected |
| req_addr | input | AW | Target word address (program address or sector address) |
| req_data | input | DW | Word to program |
| done | output | 1 | One-cycle completion pulse |
| done_ok | output | 1 | Valid with done: 1 pass, 0 fail |
| fl_addr | output | AW | Flash address bus |
| fl_dq_out | output | DW | Flash data bus, outgoing value |
| fl_dq_oe | output | 1 | Drive enable for fl_dq_out |
| fl_dq_in | input | DW | Flash data bus, incoming value |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_we_n | output | 1 | Write enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |

## Verification
The assertions take three things for granted. Every timing parameter is at least 1. `req_op` and the request fields are stable in the accepting cycle. The flash answers a read on `fl_dq_in` before the last cycle of the chip-enable low phase, with no dependence on combinational paths from the block's own outputs. The bench's flash model drives `fl_dq_in` only from a read counter that changes after chip enable rises, and it presents requests only through a handshake task that waits for `req_ready`. These two measures keep every run inside those limits.

// File: rtl/pflash_pkg.sv
package pflash_pkg;

  typedef enum logic [1:0] {
    OP_PROG   = 2'd0,
    OP_SERASE = 2'd1,
    OP_CERASE = 2'd2,
    OP_BAD    = 2'd3
  } flash_op_e;

  localparam logic [11:0] ADDR_UNLK1 = 12'h555;
  localparam logic [11:0] ADDR_UNLK2 = 12'h2AA;

  localparam logic [7:0] CMD_KEY1   = 8'hAA;
  localparam logic [7:0] CMD_KEY2   = 8'h55;
  localparam logic [7:0] CMD_ERASE  = 8'h80;
  localparam logic [7:0] CMD_PROG   = 8'hA0;
  localparam logic [7:0] CMD_SECTOR = 8'h30;
  localparam logic [7:0] CMD_CHIP   = 8'h10;
  localparam logic [7:0] CMD_RDMODE = 8'hF0;

  // Larger of two clock counts: a phase must satisfy both constraints.
  function automatic int unsigned max_cnt(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Number of command writes before polling begins.
  function automatic logic [2:0] seq_len(input flash_op_e op);
    case (op)
      OP_PROG:              return 3'd4;
      OP_SERASE, OP_CERASE: return 3'd6;
      default:              return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/pflash_cmd_table.sv
module pflash_cmd_table
  import pflash_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  flash_op_e       op,
  input  logic [2:0]      step,
  input  logic [AW-1:0]   tgt_addr,
  input  logic [DW-1:0]   wdata,
  output logic [AW-1:0]   c_addr,
  output logic [DW-1:0]   c_data
);

  localparam logic [AW-1:0] A1 = AW'(ADDR_UNLK1);
  localparam logic [AW-1:0] A2 = AW'(ADDR_UNLK2);

  always_comb begin
    c_addr = A1;
    c_data = DW'(CMD_KEY1);
    if (op == OP_PROG) begin
      case (step)
        3'd0: begin c_addr = A1;       c_data = DW'(CMD_KEY1); end
        3'd1: begin c_addr = A2;       c_data = DW'(CMD_KEY2); end
        3'd2: begin c_addr = A1;       c_data = DW'(CMD_PROG); end
        default: begin c_addr = tgt_addr; c_data = wdata; end
      endcase
    end else begin
      case (step)
        3'd0: begin c_addr = A1; c_data = DW'(CMD_KEY1);  end
        3'd1: begin c_addr = A2; c_data = DW'(CMD_KEY2);  end
        3'd2: begin c_addr = A1; c_data = DW'(CMD_ERASE); end
        3'd3: begin c_addr = A1; c_data = DW'(CMD_KEY1);  end
        3'd4: begin c_addr = A2; c_data = DW'(CMD_KEY2);  end
        default: begin
          if (op == OP_SERASE) begin
            c_addr = tgt_addr;
            c_data = DW'(CMD_SECTOR);
          end else begin
            c_addr = A1;
            c_data = DW'(CMD_CHIP);
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/pflash_bus_cycle.sv
module pflash_bus_cycle
  import pflash_pkg::*;
#(
  parameter int AW      = 20,
  parameter int DW      = 16,
  parameter int T_SETUP = 1,
  parameter int T_CP    = 1,
  parameter int T_HOLD  = 1,
  parameter int T_CPH   = 1,
  parameter int T_RD    = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          is_read,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] wdata_in,
  output logic          idle,
  output logic          fin,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_dq_out,
  output logic          fl_dq_oe,
  input  logic [DW-1:0] fl_dq_in,
  output logic          fl_ce_n,
  output logic          fl_we_n,
  output logic          fl_oe_n
);

  localparam int unsigned MAXC =
    max_cnt(max_cnt(max_cnt(T_SETUP, T_CP), max_cnt(T_HOLD, T_CPH)), T_RD);
  localparam int CW = $clog2(MAXC + 1);

  typedef enum logic [2:0] {B_IDLE, B_SETUP, B_PULSE, B_HOLD, B_GAP} bphase_e;

  bphase_e       ph_q;
  logic [CW-1:0] cnt_q;
  logic          rd_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  // Counter load value for a phase lasting n cycles.
  function automatic logic [CW-1:0] span(input int unsigned n);
    return CW'(n - 1);
  endfunction

  logic ph_end;
  assign ph_end = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= B_IDLE;
      cnt_q  <= '0;
      rd_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      rdata  <= '0;
    end else begin
      case (ph_q)
        B_IDLE: if (start) begin
          addr_q <= addr_in;
          data_q <= wdata_in;
          rd_q   <= is_read;
          ph_q   <= B_SETUP;
          cnt_q  <= span(T_SETUP);
        end
        B_SETUP: if (ph_end) begin
          ph_q  <= B_PULSE;
          cnt_q <= rd_q ? span(T_RD) : span(T_CP);
        end else cnt_q <= cnt_q - 1'b1;
        B_PULSE: if (ph_end) begin
          if (rd_q) rdata <= fl_dq_in;
          ph_q  <= B_HOLD;
          cnt_q <= span(T_HOLD);
        end else cnt_q <= cnt_q - 1'b1;
        B_HOLD: if (ph_end) begin
          ph_q  <= B_GAP;
          cnt_q <= span(T_CPH);
        end else cnt_q <= cnt_q - 1'b1;
        default: if (ph_end) ph_q <= B_IDLE;
                 else cnt_q <= cnt_q - 1'b1;
      endcase
    end
  end

  logic wr_active;
  assign wr_active = !rd_q && (ph_q == B_SETUP || ph_q == B_PULSE || ph_q == B_HOLD);

  assign idle      = (ph_q == B_IDLE);
  assign fin       = (ph_q == B_GAP) && ph_end;
  assign fl_addr   = addr_q;
  assign fl_dq_out = data_q;
  assign fl_dq_oe  = wr_active;
  assign fl_we_n   = !wr_active;
  assign fl_ce_n   = (ph_q != B_PULSE);
  assign fl_oe_n   = !(rd_q && ph_q == B_PULSE);

  // Independent count of chip-enable low cycles for the width check.
  logic [CW:0] ce_lo_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ce_lo_cnt <= '0;
    else if (fl_ce_n) ce_lo_cnt <= '0;
    else ce_lo_cnt <= ce_lo_cnt + 1'b1;
  end

  AST_CE_LOW_WIDTH: assert property (@(posedge clk) disable iff (!rst_n) $rose(fl_ce_n) |-> (ce_lo_cnt == ($past(fl_we_n) ? (CW+1)'(T_RD) : (CW+1)'(T_CP)))); // R5 R12
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (!fl_ce_n && $past(!fl_ce_n)) |-> $stable(fl_addr)); // R5
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n) ($rose(fl_ce_n) && !fl_we_n) |-> (fl_dq_oe && $stable(fl_dq_out))); // R5

endmodule

// File: rtl/pflash_seq.sv
module pflash_seq
  import pflash_pkg::*;
#(
  parameter int AW    = 20,
  parameter int DW    = 16,
  parameter int T_AS  = 1,
  parameter int T_DS  = 1,
  parameter int T_CP  = 2,
  parameter int T_AH  = 1,
  parameter int T_DH  = 1,
  parameter int T_CPH = 1,
  parameter int T_RD  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  output logic          done,
  output logic          done_ok,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_dq_out,
  output logic          fl_dq_oe,
  input  logic [DW-1:0] fl_dq_in,
  output logic          fl_ce_n,
  output logic          fl_we_n,
  output logic          fl_oe_n
);

  localparam int T_SETUP = int'(max_cnt(T_AS, T_DS));
  localparam int T_HOLD  = int'(max_cnt(T_AH, T_DH));

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_POLL, S_REREAD, S_RESET, S_DONE} seq_e;

  seq_e          st_q;
  flash_op_e     op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [2:0]    step_q;
  logic          wait_q;
  logic          ok_q;

  // Bus engine signals
  logic          bus_start, bus_read, bus_idle, bus_fin;
  logic [AW-1:0] bus_addr, cmd_addr;
  logic [DW-1:0] bus_wdata, cmd_data, bus_rdata;

  // Named status events
  logic [DW-1:0] exp_word;
  logic          poll_hit, word_ok, poll_timeout;
  logic          last_cmd, rst_cmd_fin, bad_take;

  pflash_cmd_table #(.AW(AW), .DW(DW)) u_tbl (
    .op(op_q), .step(step_q), .tgt_addr(addr_q), .wdata(data_q),
    .c_addr(cmd_addr), .c_data(cmd_data)
  );

  pflash_bus_cycle #(
    .AW(AW), .DW(DW), .T_SETUP(T_SETUP), .T_CP(T_CP),
    .T_HOLD(T_HOLD), .T_CPH(T_CPH), .T_RD(T_RD)
  ) u_bus (
    .clk(clk), .rst_n(rst_n), .start(bus_start), .is_read(bus_read),
    .addr_in(bus_addr), .wdata_in(bus_wdata),
    .idle(bus_idle), .fin(bus_fin), .rdata(bus_rdata),
    .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe),
    .fl_dq_in(fl_dq_in), .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
  );

  assign exp_word     = (op_q == OP_PROG) ? data_q : '1;
  assign poll_hit     = (bus_rdata[7] == exp_word[7]);
  assign word_ok      = (bus_rdata == exp_word);
  assign poll_timeout = bus_rdata[5];
  assign last_cmd     = (step_q == seq_len(op_q) - 3'd1);
  assign rst_cmd_fin  = bus_fin && (st_q == S_RESET);
  assign bad_take     = req_valid && req_ready && (req_op == OP_BAD);

  assign bus_read  = (st_q == S_POLL) || (st_q == S_REREAD);
  assign bus_start = (st_q == S_CMD || bus_read || st_q == S_RESET) && bus_idle && !wait_q;

  always_comb begin
    bus_addr  = cmd_addr;
    bus_wdata = cmd_data;
    if (bus_read) begin
      bus_addr  = addr_q;
      bus_wdata = '0;
    end else if (st_q == S_RESET) begin
      bus_addr  = '0;
      bus_wdata = DW'(CMD_RDMODE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      op_q   <= OP_PROG;
      addr_q <= '0;
      data_q <= '0;
      step_q <= '0;
      wait_q <= 1'b0;
      ok_q   <= 1'b0;
    end else begin
      if (bus_start) wait_q <= 1'b1;
      else if (bus_fin) wait_q <= 1'b0;
      case (st_q)
        S_IDLE: if (req_valid) begin
          op_q   <= flash_op_e'(req_op);
          addr_q <= req_addr;
          data_q <= req_data;
          step_q <= '0;
          ok_q   <= 1'b0;
          st_q   <= (req_op == OP_BAD) ? S_DONE : S_CMD;
        end
        S_CMD: if (bus_fin) begin
          if (last_cmd) st_q <= S_POLL;
          else step_q <= step_q + 3'd1;
        end
        S_POLL: if (bus_fin) begin
          if (poll_hit) begin
            if (word_ok) begin ok_q <= 1'b1; st_q <= S_DONE; end
            else st_q <= S_RESET;
          end else if (poll_timeout) st_q <= S_REREAD;
        end
        S_REREAD: if (bus_fin) begin
          if (word_ok) begin ok_q <= 1'b1; st_q <= S_DONE; end
          else st_q <= S_RESET;
        end
        S_RESET: if (bus_fin) st_q <= S_DONE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (st_q == S_IDLE);
  assign done      = (st_q == S_DONE);
  assign done_ok   = ok_q;

  AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(!fl_we_n && !fl_oe_n)); // R6
  AST_DRIVE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n) fl_dq_oe |-> !fl_we_n); // R6
  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_ready) |=> !req_ready); // R10
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> (!done && req_ready)); // R10
  AST_BADOP_NOBUS: assert property (@(posedge clk) disable iff (!rst_n) bad_take |=> (done && !done_ok && fl_ce_n)); // R11
  AST_REREAD_ONCE: assert property (@(posedge clk) disable iff (!rst_n) (bus_fin && st_q == S_REREAD) |=> (st_q != S_REREAD)); // R8
  AST_FAIL_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n) (done && !done_ok) |-> $past(rst_cmd_fin || bad_take)); // R9

endmodule

// File: tb/sim_pflash_seq.sv
module sim_pflash_seq;
  localparam int AW = 20, DW = 16;
  localparam int P_AS = 2, P_DS = 3, P_CP = 4, P_AH = 1, P_DH = 2, P_CPH = 2, P_RD = 3;
  localparam int EXP_SETUP = (P_AS > P_DS) ? P_AS : P_DS;
  localparam int EXP_HOLD  = (P_AH > P_DH) ? P_AH : P_DH;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_op = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic          done, done_ok;
  logic [AW-1:0] fl_addr;
  logic [DW-1:0] fl_dq_out, fl_dq_in;
  logic          fl_dq_oe, fl_ce_n, fl_we_n, fl_oe_n;

  pflash_seq #(.AW(AW), .DW(DW), .T_AS(P_AS), .T_DS(P_DS), .T_CP(P_CP),
               .T_AH(P_AH), .T_DH(P_DH), .T_CPH(P_CPH), .T_RD(P_RD)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
    .done(done), .done_ok(done_ok), .fl_addr(fl_addr), .fl_dq_out(fl_dq_out),
    .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in), .fl_ce_n(fl_ce_n),
    .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n));

  int n_chk = 0, n_fail = 0;

  // Flash model: status word chosen from the number of completed reads
  int            m_busy = 0;
  logic          m_to = 1'b0;
  int            m_kind = 0;
  logic [DW-1:0] m_exp = '0;
  int            rd_cnt = 0;

  function automatic logic [DW-1:0] model_word(input int k);
    logic [DW-1:0] v;
    if (k < m_busy) begin
      v = '0;
      v[7] = ~m_exp[7];
      v[5] = m_to && (k == m_busy - 1);
    end else if (m_kind == 1) v = m_exp ^ 16'h0080;
    else if (m_kind == 2) v = m_exp ^ 16'h0001;
    else v = m_exp;
    return v;
  endfunction

  assign fl_dq_in = model_word(rd_cnt);

  // Bus monitor
  logic [AW-1:0] wa [8];
  logic [DW-1:0] wd [8];
  int wr_n = 0, tbad = 0, e6 = 0;
  int pre = 0, lo = 0, post = 0, rlo = 0;
  logic seen_lo = 1'b0;
  logic p_ce = 1'b1, p_we = 1'b1, p_oe = 1'b1;
  logic [AW-1:0] last_raddr = '0;

  always @(negedge clk) if (rst_n) begin
    if (!fl_we_n && !fl_oe_n) e6++;
    if (fl_dq_oe && fl_we_n) e6++;
    if (!fl_we_n) begin
      if (fl_ce_n && !seen_lo) pre++;
      else if (!fl_ce_n) begin seen_lo = 1'b1; lo++; end
      else post++;
    end
    if (!p_ce && fl_ce_n && !p_we) begin
      if (wr_n < 8) begin wa[wr_n] = fl_addr; wd[wr_n] = fl_dq_out; end
      wr_n++;
    end
    if (!p_we && fl_we_n) begin
      if (pre != EXP_SETUP || lo != P_CP || post != EXP_HOLD) tbad++;
      pre = 0; lo = 0; post = 0; seen_lo = 1'b0;
    end
    if (!fl_oe_n) begin
      rlo++;
      if (fl_ce_n) tbad++;
    end
    if (!p_oe && fl_oe_n) begin
      if (rlo != P_RD) tbad++;
      rlo = 0;
      last_raddr = fl_addr;
      rd_cnt++;
    end
    p_ce = fl_ce_n; p_we = fl_we_n; p_oe = fl_oe_n;
  end

  task automatic check(input logic cond, input string req, input int act, input int exp);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic setup_model(input int nb, input logic to, input int kind, input logic [DW-1:0] ew);
    @(posedge clk);
    m_busy = nb; m_to = to; m_kind = kind; m_exp = ew;
    rd_cnt = 0; wr_n = 0; tbad = 0; e6 = 0;
  endtask

  task automatic do_req(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d, output logic ok);
    int n;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R10 ready low after accept", req_ready, 0);
    n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    check(done == 1'b1, "R10 done seen", done, 1);
    ok = done_ok;
    @(negedge clk);
    check(done == 1'b0, "R10 done one cycle", done, 0);
    check(req_ready == 1'b1, "R10 ready after done", req_ready, 1);
  endtask

  task automatic chk_w(input int i, input logic [AW-1:0] a, input logic [DW-1:0] d, input string req);
    check(wa[i] == a && wd[i] == d, req, {wa[i], wd[i]}, {a, d});
  endtask

  task automatic chk_unlock(input string req);
    chk_w(0, 20'h555, 16'h00AA, req);
    chk_w(1, 20'h2AA, 16'h0055, req);
  endtask

  task automatic chk_erase_head(input string req);
    chk_unlock(req);
    chk_w(2, 20'h555, 16'h0080, req);
    chk_w(3, 20'h555, 16'h00AA, req);
    chk_w(4, 20'h2AA, 16'h0055, req);
  endtask

  task automatic chk_bus(input string req);
    check(tbad == 0, "R5 R12 cycle timing", tbad, 0);
    check(e6 == 0, "R6 enable exclusion", e6, 0);
  endtask

  task automatic t_reset;
    check(fl_ce_n && fl_we_n && fl_oe_n, "R1 strobes high", {fl_ce_n, fl_we_n, fl_oe_n}, 7);
    check(!fl_dq_oe, "R1 bus released", fl_dq_oe, 0);
    check(req_ready && !done, "R1 ready/done", {req_ready, done}, 2);
  endtask

  task automatic t_prog(input logic [AW-1:0] a, input logic [DW-1:0] d, input int nb);
    logic ok;
    setup_model(nb, 1'b0, 0, d);
    do_req(2'd0, a, d, ok);
    check(ok == 1'b1, "R7 program pass", ok, 1);
    check(wr_n == 4, "R2 write count", wr_n, 4);
    chk_unlock("R2 unlock");
    chk_w(2, 20'h555, 16'h00A0, "R2 program cmd");
    chk_w(3, a, d, "R2 program data");
    check(rd_cnt == nb + 1, "R7 poll count", rd_cnt, nb + 1);
    check(last_raddr == a, "R7 poll address", last_raddr, a);
    chk_bus("R5");
  endtask

  task automatic t_serase;
    logic ok;
    setup_model(2, 1'b0, 0, 16'hFFFF);
    do_req(2'd1, 20'h1C000, 16'h0000, ok);
    check(ok == 1'b1, "R7 sector erase pass", ok, 1);
    check(wr_n == 6, "R3 write count", wr_n, 6);
    chk_erase_head("R3 prefix");
    chk_w(5, 20'h1C000, 16'h0030, "R3 sector cmd");
    check(rd_cnt == 3, "R7 erase poll count", rd_cnt, 3);
    chk_bus("R5");
  endtask

  task automatic t_cerase;
    logic ok;
    setup_model(1, 1'b0, 0, 16'hFFFF);
    do_req(2'd2, 20'h00123, 16'h0000, ok);
    check(ok == 1'b1, "R7 chip erase pass", ok, 1);
    check(wr_n == 6, "R4 write count", wr_n, 6);
    chk_erase_head("R4 prefix");
    chk_w(5, 20'h555, 16'h0010, "R4 chip cmd");
    check(last_raddr == 20'h00123, "R7 chip poll address", last_raddr, 20'h00123);
  endtask

  task automatic t_timeout_pass;
    logic ok;
    setup_model(2, 1'b1, 0, 16'h3456);
    do_req(2'd0, 20'h00F00, 16'h3456, ok);
    check(ok == 1'b1, "R8 reread pass", ok, 1);
    check(rd_cnt == 3, "R8 one extra read", rd_cnt, 3);
    check(wr_n == 4, "R8 no reset cmd", wr_n, 4);
  endtask

  task automatic t_timeout_fail;
    logic ok;
    setup_model(1, 1'b1, 1, 16'h00C3);
    do_req(2'd0, 20'h00A00, 16'h00C3, ok);
    check(ok == 1'b0, "R9 timeout fail", ok, 0);
    check(rd_cnt == 2, "R8 single reread", rd_cnt, 2);
    check(wr_n == 5, "R9 reset written", wr_n, 5);
    chk_w(4, 20'h00000, 16'h00F0, "R9 reset cmd");
    chk_bus("R5");
  endtask

  task automatic t_verify_fail;
    logic ok;
    setup_model(1, 1'b0, 2, 16'h5A80);
    do_req(2'd0, 20'h00B00, 16'h5A80, ok);
    check(ok == 1'b0, "R9 word mismatch fail", ok, 0);
    check(wr_n == 5, "R9 reset written", wr_n, 5);
    chk_w(4, 20'h00000, 16'h00F0, "R9 reset cmd");
  endtask

  task automatic t_badop;
    logic ok;
    setup_model(0, 1'b0, 0, 16'h0000);
    do_req(2'd3, 20'h00001, 16'h1111, ok);
    check(ok == 1'b0, "R11 rejected", ok, 0);
    check(wr_n == 0 && rd_cnt == 0, "R11 no bus cycle", wr_n + rd_cnt, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_prog(20'h04321, 16'h12C5, 3);
    t_prog(20'h00010, 16'h0042, 0);
    t_serase();
    t_cerase();
    t_timeout_pass();
    t_timeout_fail();
    t_verify_fail();
    t_badop();
    t_prog(20'hFFFFF, 16'hFFFF, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R10 watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule